// File: doc/BRIEF.md
# Packed Word Multiply-Add Unit

This block is a SIMD datapath stage. It takes two packed operands made of 16-bit signed lanes and multiplies each lane of one operand by the matching lane of the other. The two 32-bit products of each adjacent lane pair are then added into one 32-bit result lane. The sum wraps rather than saturates. The only input that overflows is a pair in which all four words are 0x8000, and that pair yields 0x80000000.

A mode bit picks the operand width. Narrow mode uses 64 bits and gives two result lanes. Wide mode uses 128 bits and gives four result lanes. The datapath is one 64-bit half wide, so narrow operations are accepted every cycle. A wide operation is split into two passes on back-to-back cycles, and the input ready drops for the one cycle that the second pass takes. A back end joins the two halves and raises the output valid once. The result carries a tag that echoes the mode.

The pipeline has a fixed depth. Results leave in the order the operations were accepted. The block has no flags and no status outputs.

Top module: `pmadd_unit`

## Requirements
- R1: Operand lane i occupies bits [16i+15:16i] and is read as a signed two's-complement word. Result lane k (bits [32k+31:32k]) equals a[2k]*b[2k] + a[2k+1]*b[2k+1], where each product is a signed 32-bit value.
- R2: The sum is not saturated. When a[2k], b[2k], a[2k+1] and b[2k+1] are all 0x8000, result lane k is 0x80000000. A pair that mixes 0x8000 and 0x7FFF gives its exact value.
- R3: In narrow mode (in_wide_i=0) the result uses only operand bits [63:0]. Result lanes 0 and 1 are produced, out_data_o[127:64] is zero, and operand bits [127:64] have no effect.
- R4: In wide mode (in_wide_i=1) all four result lanes are produced from operand bits [127:0].
- R5: out_wide_o equals the in_wide_i value of the operation being delivered.
- R6: A narrow operation accepted at a clock edge shows out_valid_o exactly PIPE_DEPTH cycles later. Narrow operations can be accepted on consecutive cycles.
- R7: After a wide operation is accepted, in_ready_o is low for exactly the next cycle. The wide result shows PIPE_DEPTH+1 cycles after acceptance.
- R8: Each accepted operation gives exactly one out_valid_o pulse, in acceptance order. No pulse appears without an accepted operation.
- R9: While rst_ni is low, out_valid_o is 0 and in_ready_o is 1. Operations in flight when reset is asserted never produce output.
- R10: An operation is accepted only when in_valid_i and in_ready_o are both high. Data presented while in_ready_o is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation request |
| in_ready_o | output | 1 | Block can accept an operation this cycle |
| in_wide_i | input | 1 | 1: 128-bit operands, 0: 64-bit operands |
| in_a_i | input | 128 | First packed operand |
| in_b_i | input | 128 | Second packed operand |
| out_valid_o | output | 1 | Result valid |
| out_wide_o | output | 1 | Mode of the delivered result |
| out_data_o | output | 128 | Packed 32-bit result lanes |

## Verification
The hardest situation to reach is the one-cycle stall after a wide acceptance when it meets further traffic. The stimulus holds in_valid_i high with junk data during that cycle. It also issues wide operations back to back, so the second pass, the half-joining register and the next acceptance all overlap in the pipeline. Random runs mix the modes with random gaps. A reset asserted while operations are in flight shows that the discarded work never reaches the output. Directed operands cover the all-0x8000 wrap and the 0x8000/0x7FFF mixes.

// File: rtl/pmadd_pkg.sv
package pmadd_pkg;
  // control bits that travel with each half-pass
  typedef struct packed {
    logic vld;
    logic wide;
    logic hi;   // upper half of a wide operation
  } pm_ctl_t;
endpackage

// File: rtl/pmadd_pair.sv
module pmadd_pair #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0]   a_lo_i,
  input  logic [LANE_W-1:0]   a_hi_i,
  input  logic [LANE_W-1:0]   b_lo_i,
  input  logic [LANE_W-1:0]   b_hi_i,
  output logic [2*LANE_W-1:0] sum_o
);
  localparam int RES_W = 2 * LANE_W;
  localparam logic [LANE_W-1:0] MIN_W = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [RES_W-1:0]  MIN_R = {1'b1, {(RES_W-1){1'b0}}};

  logic signed [RES_W-1:0] p_lo, p_hi;

  always_comb begin
    p_lo  = RES_W'($signed(a_lo_i)) * RES_W'($signed(b_lo_i));
    p_hi  = RES_W'($signed(a_hi_i)) * RES_W'($signed(b_hi_i));
    sum_o = p_lo + p_hi;  // wraps, no saturation
  end

  always_comb begin
    if (a_lo_i == MIN_W && a_hi_i == MIN_W && b_lo_i == MIN_W && b_hi_i == MIN_W)
      assert_wrap_R2: assert (sum_o == MIN_R);
  end
endmodule

// File: rtl/pmadd_issue.sv
module pmadd_issue
  import pmadd_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_wide_i,
  input  logic [2*HALF_W-1:0] in_a_i,
  input  logic [2*HALF_W-1:0] in_b_i,
  output logic              ready_o,
  output pm_ctl_t           iss_ctl_o,
  output logic [HALF_W-1:0] iss_a_o,
  output logic [HALF_W-1:0] iss_b_o
);
  logic              busy_q;
  logic [HALF_W-1:0] hold_a_q, hold_b_q;
  logic              take_wide;

  assign ready_o   = !busy_q;
  assign take_wide = in_valid_i && !busy_q && in_wide_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      iss_ctl_o <= '0;
    end else if (busy_q) begin
      busy_q    <= 1'b0;
      iss_ctl_o <= '{vld: 1'b1, wide: 1'b1, hi: 1'b1};
    end else begin
      busy_q    <= take_wide;
      iss_ctl_o <= '{vld: in_valid_i, wide: in_wide_i, hi: 1'b0};
    end
  end

  always_ff @(posedge clk_i) begin
    if (busy_q) begin
      iss_a_o <= hold_a_q;
      iss_b_o <= hold_b_q;
    end else begin
      iss_a_o <= in_a_i[HALF_W-1:0];
      iss_b_o <= in_b_i[HALF_W-1:0];
    end
    if (take_wide) begin
      hold_a_q <= in_a_i[2*HALF_W-1:HALF_W];
      hold_b_q <= in_b_i[2*HALF_W-1:HALF_W];
    end
  end

  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ready_o && in_wide_i) |=> !ready_o);
  assert_stall_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);
endmodule

// File: rtl/pmadd_delay.sv
module pmadd_delay
  import pmadd_pkg::*;
#(
  parameter int W     = 64,
  parameter int DEPTH = 7
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pm_ctl_t ctl_i,
  input  logic [W-1:0] dat_i,
  output pm_ctl_t ctl_o,
  output logic [W-1:0] dat_o
);
  if (DEPTH == 0) begin : g_thru
    assign ctl_o = ctl_i;
    assign dat_o = dat_i;
  end else begin : g_pipe
    pm_ctl_t      ctl_q [DEPTH];
    logic [W-1:0] dat_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < DEPTH; s++) ctl_q[s] <= '0;
      end else begin
        for (int s = DEPTH - 1; s > 0; s--) ctl_q[s] <= ctl_q[s-1];
        ctl_q[0] <= ctl_i;
      end
    end

    always_ff @(posedge clk_i) begin
      for (int s = DEPTH - 1; s > 0; s--) dat_q[s] <= dat_q[s-1];
      dat_q[0] <= dat_i;
    end

    assign ctl_o = ctl_q[DEPTH-1];
    assign dat_o = dat_q[DEPTH-1];
  end
endmodule

// File: rtl/pmadd_unit.sv
module pmadd_unit
  import pmadd_pkg::*;
#(
  parameter int LANE_W     = 16,
  parameter int OUT_LANES  = 4,
  parameter int PIPE_DEPTH = 8   // >= 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                in_valid_i,
  output logic                                in_ready_o,
  input  logic                                in_wide_i,
  input  logic [OUT_LANES*2*LANE_W-1:0]       in_a_i,
  input  logic [OUT_LANES*2*LANE_W-1:0]       in_b_i,
  output logic                                out_valid_o,
  output logic                                out_wide_o,
  output logic [OUT_LANES*2*LANE_W-1:0]       out_data_o
);
  localparam int RES_W      = 2 * LANE_W;
  localparam int FULL_W     = OUT_LANES * RES_W;
  localparam int HALF_W     = FULL_W / 2;
  localparam int PASS_LANES = OUT_LANES / 2;

  pm_ctl_t           iss_ctl, t_ctl;
  logic [HALF_W-1:0] iss_a, iss_b, sum_w, t_dat, lo_hold_q;

  pmadd_issue #(.HALF_W(HALF_W)) i_issue (
    .clk_i, .rst_ni, .in_valid_i, .in_wide_i, .in_a_i, .in_b_i,
    .ready_o(in_ready_o), .iss_ctl_o(iss_ctl), .iss_a_o(iss_a), .iss_b_o(iss_b)
  );

  for (genvar g = 0; g < PASS_LANES; g++) begin : g_pair
    pmadd_pair #(.LANE_W(LANE_W)) i_pair (
      .a_lo_i(iss_a[g*RES_W +: LANE_W]),
      .a_hi_i(iss_a[g*RES_W+LANE_W +: LANE_W]),
      .b_lo_i(iss_b[g*RES_W +: LANE_W]),
      .b_hi_i(iss_b[g*RES_W+LANE_W +: LANE_W]),
      .sum_o (sum_w[g*RES_W +: RES_W])
    );
  end

  pmadd_delay #(.W(HALF_W), .DEPTH(PIPE_DEPTH-1)) i_delay (
    .clk_i, .rst_ni, .ctl_i(iss_ctl), .dat_i(sum_w), .ctl_o(t_ctl), .dat_o(t_dat)
  );

  // park the lower half of a wide result until its upper half arrives
  always_ff @(posedge clk_i) begin
    if (t_ctl.vld && t_ctl.wide && !t_ctl.hi) lo_hold_q <= t_dat;
  end

  assign out_valid_o = t_ctl.vld && (!t_ctl.wide || t_ctl.hi);
  assign out_wide_o  = t_ctl.wide;
  assign out_data_o  = t_ctl.wide ? {t_dat, lo_hold_q} : {{HALF_W{1'b0}}, t_dat};

  assert_halves_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_ctl.vld && t_ctl.wide && !t_ctl.hi) |=> (t_ctl.vld && t_ctl.wide && t_ctl.hi));
  assert_hi_after_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_ctl.vld && t_ctl.hi) |-> $past(t_ctl.vld && t_ctl.wide && !t_ctl.hi));
  assert_narrow_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_wide_o) |-> (out_data_o[FULL_W-1:HALF_W] == '0));
  assert_reset_idle_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && in_ready_o));
endmodule

// File: tb/test_pmadd_unit.sv
module test_pmadd_unit;
  localparam int DEPTH = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_wide = 1'b0;
  logic [127:0] in_a = '0, in_b = '0;
  logic         in_ready, out_valid, out_wide;
  logic [127:0] out_data;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;
  bit exp_ready = 1;
  string cur_tag = "R1";

  typedef struct {
    logic [127:0] d;
    logic         w;
    int           stamp;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  pmadd_unit #(.LANE_W(16), .OUT_LANES(4), .PIPE_DEPTH(DEPTH)) i_pmadd_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_wide_i(in_wide), .in_a_i(in_a), .in_b_i(in_b),
    .out_valid_o(out_valid), .out_wide_o(out_wide), .out_data_o(out_data)
  );

  function automatic logic [127:0] ref_calc(logic [127:0] a, logic [127:0] b, logic w);
    logic [127:0] r;
    int s;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      if (w || k < 2) begin
        s = int'($signed(a[32*k +: 16])) * int'($signed(b[32*k +: 16]))
          + int'($signed(a[32*k+16 +: 16])) * int'($signed(b[32*k+16 +: 16]));
        r[32*k +: 32] = s;
      end
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference model: acceptance and ready
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      exp_ready <= 1'b1;
    end else begin
      if (in_valid && exp_ready) begin
        q.push_back('{d: ref_calc(in_a, in_b, in_wide), w: in_wide, stamp: cyc, tag: cur_tag});
        exp_ready <= !in_wide;
      end else begin
        exp_ready <= 1'b1;
      end
    end
    cyc <= cyc + 1;
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(in_ready == exp_ready, "R7", "ready", 128'(in_ready), 128'(exp_ready));
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(0, "R8", "unexpected out_valid", 128'(out_valid), 128'(0));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_data == e.d, e.tag, "data (R8 order)", out_data, e.d);
          chk(out_wide == e.w, "R5", "wide tag", 128'(out_wide), 128'(e.w));
          chk(cyc - e.stamp == (e.w ? DEPTH + 1 : DEPTH), e.w ? "R7" : "R6", "latency",
              128'(cyc - e.stamp), 128'(e.w ? DEPTH + 1 : DEPTH));
        end
      end
    end
  end

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(logic [127:0] a, logic [127:0] b, logic w, string tag);
    cur_tag  = tag;
    in_valid = 1'b1; in_a = a; in_b = b; in_wide = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", "valid in reset", 128'(out_valid), 128'(0));
      chk(in_ready == 1'b1, "R9", "ready in reset", 128'(in_ready), 128'(1));
    end
    rst_n = 1'b1;
    @(negedge clk);

    // wrap corner, both modes
    send({8{16'h8000}}, {8{16'h8000}}, 1'b1, "R2");
    send({8{16'h8000}}, {8{16'h8000}}, 1'b0, "R2");
    // mixed extremes
    send({4{16'h8000, 16'h7FFF}}, {4{16'h8000, 16'h8000}}, 1'b1, "R2");
    send({4{16'h7FFF, 16'h8000}}, {4{16'h7FFF, 16'h7FFF}}, 1'b1, "R2");
    send({8{16'h7FFF}}, {8{16'h7FFF}}, 1'b1, "R4");
    send({8{16'hFFFF}}, {8{16'h0001}}, 1'b1, "R1");
    send(128'h0000_0003_FFFE_0005_0004_FFFF_0002_0007,
         128'h0009_0008_0007_0006_0005_0004_0003_0002, 1'b1, "R1");
    // narrow with junk in the upper half
    send({64'hDEAD_BEEF_1234_5678, 64'h0001_0002_0003_0004},
         {64'hCAFE_F00D_8765_4321, 64'h0005_0006_0007_0008}, 1'b0, "R3");
    drain();

    // back-to-back narrow burst
    for (int i = 0; i < 12; i++) send(rnd128(), rnd128(), 1'b0, "R6");
    // back-to-back wide burst
    for (int i = 0; i < 6; i++) send(rnd128(), rnd128(), 1'b1, "R4");
    drain();

    // request held during the stall cycle must be ignored
    send(rnd128(), rnd128(), 1'b1, "R10");
    chk(in_ready == 1'b0, "R10", "stall cycle ready", 128'(in_ready), 128'(0));
    in_valid = 1'b1; in_a = '1; in_b = '1; in_wide = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    send(rnd128(), rnd128(), 1'b0, "R10");
    drain();

    // random mix with gaps
    for (int i = 0; i < 300; i++) begin
      logic w;
      w = 1'($urandom_range(0, 1));
      send(rnd128(), rnd128(), w, w ? "R4" : "R1");
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    drain();

    // reset with work in flight
    for (int i = 0; i < 3; i++) send(rnd128(), rnd128(), 1'($urandom_range(0, 1)), "R9");
    #2 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (DEPTH + 3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", "flushed output", 128'(out_valid), 128'(0));
    end
    send({8{16'h8000}}, {8{16'h8000}}, 1'b1, "R2");
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule